// File: doc/BRIEF.md
# Pointer Version Tag Checker

This block guards memory accesses with version tags carried in the top bits of every pointer. For each access it gets the virtual address, the access kind, the per-task master enable, the per-page check bit from the translation entry and a precise-mode control bit. It presents the line index of the addressed 64-byte line on a lookup port and receives the tag stored for that line in the same cycle. It then compares the stored tag with the pointer tag and gives one of three verdicts: allow, precise trap or disrupting trap.

The verdict leaves through a one-deep registered stage with a valid/ready handshake toward the pipeline. A trap response carries its trap-type code and an address. For a precise trap this is the data address. For a disrupting trap it is the program counter of the first mismatching store. That PC stays latched behind a sticky pending flag until software clears it.

Top module: `ptag_chk`

## Requirements
- R1: The pointer tag is `req_vaddr[63:60]`. When checking is active and this tag equals `line_tag`, the verdict is allow (`rsp_verdict` = 2'b00) with `rsp_tt` = 0 and `rsp_addr` = 0.
- R2: An access is checked only when `task_en` and `page_chk` are both 1. Otherwise the verdict is allow, whatever the tags are.
- R3: A tag value of 4'h0 or 4'hF, in the pointer or in `line_tag`, matches any tag and never gives a mismatch.
- R4: A checked store (`req_kind` = 2'b01) whose tags differ, with `precise_mode` = 0, gives a disrupting trap: `rsp_verdict` = 2'b10, `rsp_tt` = 8'h7E, and `rsp_addr` holds the PC of the first mismatching store (see R9).
- R5: A checked store whose tags differ, with `precise_mode` = 1, gives a precise trap: `rsp_verdict` = 2'b01, `rsp_tt` = 8'h1A, `rsp_addr` = `req_vaddr`.
- R6: A checked load (`req_kind` = 2'b00, and also the unused code 2'b11) whose tags differ always gives the precise trap of R5, whatever `precise_mode` is.
- R7: A non-faulting load (`req_kind` = 2'b10) is never checked and always gets allow.
- R8: `line_addr` equals `req_vaddr[59:6]` in the same cycle, so one stored tag covers one 64-byte line.
- R9: The first disrupting trap sets `derr_pending` and latches its `req_pc` in `derr_pc`. Later disrupting traps report and keep that PC until `derr_clear` is pulsed. A clear that comes in the same cycle as a new disrupting trap takes the new PC.
- R10: A request is accepted when `req_valid` and `req_ready` are both 1. Its result appears on the response the following cycle with `rsp_valid` = 1. `req_ready` is 0 while a response is held with `rsp_ready` = 0, and a held response stays stable.
- R11: After a reset, `rsp_valid` and `derr_pending` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 00 load, 01 store, 10 non-faulting load, 11 treated as load |
| req_vaddr | input | 64 | Virtual address with the tag in bits 63:60 |
| req_pc | input | 64 | PC of the accessing instruction |
| task_en | input | 1 | Per-task master enable for tag checking |
| page_chk | input | 1 | Per-page tag-check bit from the translation entry |
| precise_mode | input | 1 | Store mismatches trap precisely when 1 |
| line_addr | output | 54 | Line index sent to the tag lookup |
| line_tag | input | 4 | Stored tag returned for `line_addr` |
| derr_clear | input | 1 | Clears the sticky disrupting-error flag |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Pipeline takes the response |
| rsp_verdict | output | 2 | 00 allow, 01 precise trap, 10 disrupting trap |
| rsp_tt | output | 8 | Trap type code, 0 when allowed |
| rsp_addr | output | 64 | Faulting address or recorded PC, 0 when allowed |
| derr_pending | output | 1 | A disrupting error is recorded |
| derr_pc | output | 64 | PC of the first recorded disrupting error |

## Verification
The properties assume that `line_tag` is valid in the same cycle as the request that drives `line_addr`. They also assume that `rsp_ready` is the only thing that lets a held response go. The stimulus keeps to these assumptions: the bench returns the stored tag for each request in that request's own cycle, and it holds the response only in a directed stall sequence where no new request is raised. The random accesses mix matching tags, wildcard tags, gated-off checks and all access kinds, with clears scattered among disrupting stores, so that the sticky PC is exercised both in its held and in its released state.

// File: rtl/ptag_pkg.sv
// Package: shared codes for the pointer version tag checker.
// Assumes: an 8-bit trap type field and a 2-bit access kind.
package ptag_pkg;
    localparam logic [1:0] KIND_LOAD   = 2'b00;
    localparam logic [1:0] KIND_STORE  = 2'b01;
    localparam logic [1:0] KIND_NFLOAD = 2'b10;

    localparam logic [1:0] VERD_ALLOW   = 2'b00;
    localparam logic [1:0] VERD_PRECISE = 2'b01;
    localparam logic [1:0] VERD_DISRUPT = 2'b10;

    localparam int         TT_W       = 8;
    localparam logic [7:0] TT_PRECISE = 8'h1a;
    localparam logic [7:0] TT_DISRUPT = 8'h7e;
endpackage

// File: rtl/ptag_compare.sv
// Module: combinational tag comparison and verdict selection.
// Assumes: both tags are valid in the same cycle; all-zero and all-ones
// tag values are wildcards on either side.
module ptag_compare
    import ptag_pkg::*;
#(
    parameter int TAG_W = 4
) (
    input  logic [TAG_W-1:0] ptr_tag,
    input  logic [TAG_W-1:0] mem_tag,
    input  logic [1:0]       kind,
    input  logic             task_en,
    input  logic             page_chk,
    input  logic             precise_mode,
    output logic [1:0]       verdict
);
    logic checked;
    logic wild;
    logic mismatch;

    // Decide whether the access is subject to a tag check and whether it fails.
    always_comb begin
        checked  = task_en && page_chk && (kind != KIND_NFLOAD);
        wild     = (ptr_tag == '0) || (ptr_tag == '1) ||
                   (mem_tag == '0) || (mem_tag == '1);
        mismatch = checked && !wild && (ptr_tag != mem_tag);
    end

    // Map a failure to a precise or disrupting verdict by access kind and mode.
    always_comb begin
        if (!mismatch) begin
            verdict = VERD_ALLOW;
        end else if ((kind == KIND_STORE) && !precise_mode) begin
            verdict = VERD_DISRUPT;
        end else begin
            verdict = VERD_PRECISE;
        end
    end
endmodule

// File: rtl/ptag_sticky.sv
// Module: sticky record of the first disrupting error PC.
// Assumes: capture is asserted only for an accepted disrupting verdict;
// a clear in the same cycle as a capture lets the new PC in.
module ptag_sticky #(
    parameter int VA_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            clear,
    input  logic [VA_W-1:0] pc_in,
    output logic            pending,
    output logic [VA_W-1:0] pc_held,
    output logic [VA_W-1:0] pc_report
);
    // Hold the first PC until software clears the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            pc_held <= '0;
        end else if (capture && (!pending || clear)) begin
            pending <= 1'b1;
            pc_held <= pc_in;
        end else if (clear) begin
            pending <= 1'b0;
        end
    end

    // PC to report for a disrupting trap accepted this cycle.
    always_comb begin
        pc_report = (pending && !clear) ? pc_held : pc_in;
    end
endmodule

// File: rtl/ptag_out_stage.sv
// Module: one-deep registered response stage with valid/ready.
// Assumes: load is only asserted when in_ready is high.
module ptag_out_stage #(
    parameter int VA_W = 64,
    parameter int TT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [1:0]      verdict_in,
    input  logic [TT_W-1:0] tt_in,
    input  logic [VA_W-1:0] addr_in,
    input  logic            rsp_ready,
    output logic            in_ready,
    output logic            rsp_valid,
    output logic [1:0]      rsp_verdict,
    output logic [TT_W-1:0] rsp_tt,
    output logic [VA_W-1:0] rsp_addr
);
    // Free when empty or when the held response is being taken.
    always_comb begin
        in_ready = !rsp_valid || rsp_ready;
    end

    // Register a new result, or drop the taken one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_verdict <= '0;
            rsp_tt      <= '0;
            rsp_addr    <= '0;
        end else if (load) begin
            rsp_valid   <= 1'b1;
            rsp_verdict <= verdict_in;
            rsp_tt      <= tt_in;
            rsp_addr    <= addr_in;
        end else if (rsp_ready) begin
            rsp_valid   <= 1'b0;
        end
    end
endmodule

// File: rtl/ptag_chk.sv
// Module: pointer version tag checker top.
// Splits the pointer tag and line index from the address, compares tags,
// tracks the sticky disrupting PC and registers the response.
// Assumes: line_tag answers line_addr in the same cycle.
module ptag_chk
    import ptag_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int TAG_W      = 4,
    parameter int LINE_BYTES = 64,
    localparam int LINE_LSB  = $clog2(LINE_BYTES),
    localparam int TAG_LSB   = VA_W - TAG_W,
    localparam int LINE_W    = TAG_LSB - LINE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [VA_W-1:0]   req_pc,
    input  logic              task_en,
    input  logic              page_chk,
    input  logic              precise_mode,
    output logic [LINE_W-1:0] line_addr,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic              derr_clear,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_verdict,
    output logic [TT_W-1:0]   rsp_tt,
    output logic [VA_W-1:0]   rsp_addr,
    output logic              derr_pending,
    output logic [VA_W-1:0]   derr_pc
);
    logic [1:0]      verdict;
    logic [TT_W-1:0] tt_next;
    logic [VA_W-1:0] addr_next;
    logic [VA_W-1:0] pc_report;
    logic            accept;

    // Line index for the tag lookup.
    always_comb begin
        line_addr = req_vaddr[TAG_LSB-1:LINE_LSB];
    end

    ptag_compare #(.TAG_W(TAG_W)) u_cmp (
        .ptr_tag      (req_vaddr[VA_W-1:TAG_LSB]),
        .mem_tag      (line_tag),
        .kind         (req_kind),
        .task_en      (task_en),
        .page_chk     (page_chk),
        .precise_mode (precise_mode),
        .verdict      (verdict)
    );

    // Request handshake.
    always_comb begin
        accept = req_valid && req_ready;
    end

    ptag_sticky #(.VA_W(VA_W)) u_sticky (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (accept && (verdict == VERD_DISRUPT)),
        .clear     (derr_clear),
        .pc_in     (req_pc),
        .pending   (derr_pending),
        .pc_held   (derr_pc),
        .pc_report (pc_report)
    );

    // Trap code and reported address for the verdict.
    always_comb begin
        case (verdict)
            VERD_PRECISE: begin
                tt_next   = TT_PRECISE;
                addr_next = req_vaddr;
            end
            VERD_DISRUPT: begin
                tt_next   = TT_DISRUPT;
                addr_next = pc_report;
            end
            default: begin
                tt_next   = '0;
                addr_next = '0;
            end
        endcase
    end

    ptag_out_stage #(.VA_W(VA_W), .TT_W(TT_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .verdict_in  (verdict),
        .tt_in       (tt_next),
        .addr_in     (addr_next),
        .rsp_ready   (rsp_ready),
        .in_ready    (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_verdict (rsp_verdict),
        .rsp_tt      (rsp_tt),
        .rsp_addr    (rsp_addr)
    );
endmodule

// File: rtl/ptag_chk_props.sv
// Module: property checker bound to ptag_chk.
// Assumes: line_tag belongs to the request of the same cycle.
module ptag_chk_props #(
    parameter int VA_W   = 64,
    parameter int TAG_W  = 4,
    parameter int LINE_W = 54
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic [VA_W-1:0]   req_vaddr,
    input logic              task_en,
    input logic              page_chk,
    input logic [TAG_W-1:0]  line_tag,
    input logic              derr_clear,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [1:0]        rsp_verdict,
    input logic [7:0]        rsp_tt,
    input logic [VA_W-1:0]   rsp_addr,
    input logic              derr_pending,
    input logic [VA_W-1:0]   derr_pc
);
    logic acc;
    assign acc = req_valid && req_ready;

    AST_GATED_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !(task_en && page_chk) |=> rsp_verdict == 2'b00); // R2
    AST_WILD_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (line_tag == '0 || line_tag == '1) |=> rsp_verdict == 2'b00); // R3
    AST_DISRUPT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_verdict == 2'b10 |-> rsp_tt == 8'h7e); // R4
    AST_PRECISE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_verdict == 2'b01 |-> rsp_tt == 8'h1a); // R5
    AST_LOAD_NOT_DEFERRED: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_kind == 2'b00 |=> rsp_verdict != 2'b10); // R6
    AST_NFLOAD_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_kind == 2'b10 |=> rsp_verdict == 2'b00 && rsp_tt == 8'h00); // R7
    AST_PC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        derr_pending && !derr_clear |=> derr_pending && $stable(derr_pc)); // R9
    AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid); // R10
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_verdict) &&
        $stable(rsp_tt) && $stable(rsp_addr)); // R10
    AST_NO_BAD_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_verdict != 2'b11); // R1
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> !rsp_valid && !derr_pending); // R11
endmodule

bind ptag_chk ptag_chk_props #(
    .VA_W   (VA_W),
    .TAG_W  (TAG_W),
    .LINE_W (LINE_W)
) u_props (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_kind     (req_kind),
    .req_vaddr    (req_vaddr),
    .task_en      (task_en),
    .page_chk     (page_chk),
    .line_tag     (line_tag),
    .derr_clear   (derr_clear),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_verdict  (rsp_verdict),
    .rsp_tt       (rsp_tt),
    .rsp_addr     (rsp_addr),
    .derr_pending (derr_pending),
    .derr_pc      (derr_pc)
);

// File: tb/ptag_chk_test.sv
module ptag_chk_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'b00;
    logic [63:0] req_vaddr = '0;
    logic [63:0] req_pc = '0;
    logic        task_en = 1'b0;
    logic        page_chk = 1'b0;
    logic        precise_mode = 1'b0;
    logic [53:0] line_addr;
    logic [3:0]  line_tag = '0;
    logic        derr_clear = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [1:0]  rsp_verdict;
    logic [7:0]  rsp_tt;
    logic [63:0] rsp_addr;
    logic        derr_pending;
    logic [63:0] derr_pc;

    int n_chk = 0;
    int n_bad = 0;
    bit          m_pend = 1'b0;
    logic [63:0] m_pc = '0;

    always #4 clk = ~clk;

    ptag_chk uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_vaddr(req_vaddr), .req_pc(req_pc),
        .task_en(task_en), .page_chk(page_chk), .precise_mode(precise_mode),
        .line_addr(line_addr), .line_tag(line_tag), .derr_clear(derr_clear),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_verdict(rsp_verdict),
        .rsp_tt(rsp_tt), .rsp_addr(rsp_addr), .derr_pending(derr_pending),
        .derr_pc(derr_pc)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit is_wild(input logic [3:0] t);
        return (t == 4'h0) || (t == 4'hf);
    endfunction

    // Expected verdict from the requirements.
    function automatic logic [1:0] exp_verdict(input logic [1:0] k, input logic [3:0] pt,
            input logic [3:0] mt, input bit en, input bit pg, input bit pm);
        if (k == 2'b10 || !en || !pg || is_wild(pt) || is_wild(mt) || pt == mt)
            return 2'b00;
        if (k == 2'b01 && !pm) return 2'b10;
        return 2'b01;
    endfunction

    function automatic string req_of(input logic [1:0] k, input logic [3:0] pt,
            input logic [3:0] mt, input bit en, input bit pg, input bit pm);
        if (k == 2'b10) return "R7";
        if (!en || !pg) return "R2";
        if (is_wild(pt) || is_wild(mt)) return "R3";
        if (pt == mt) return "R1";
        if (k == 2'b01 && !pm) return "R4";
        if (k == 2'b01) return "R5";
        return "R6";
    endfunction

    task automatic do_req(input logic [1:0] k, input logic [63:0] va, input logic [63:0] pc,
            input bit en, input bit pg, input bit pm, input logic [3:0] mt, input bit clr);
        logic [1:0]  ev;
        logic [7:0]  ett;
        logic [63:0] ea;
        string       rq;
        if (clr) m_pend = 1'b0;
        ev  = exp_verdict(k, va[63:60], mt, en, pg, pm);
        rq  = req_of(k, va[63:60], mt, en, pg, pm);
        ett = (ev == 2'b01) ? 8'h1a : (ev == 2'b10) ? 8'h7e : 8'h00;
        ea  = (ev == 2'b01) ? va : (ev == 2'b10) ? (m_pend ? m_pc : pc) : 64'd0;
        if (ev == 2'b10 && !m_pend) begin
            m_pend = 1'b1;
            m_pc   = pc;
        end
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_vaddr = va; req_pc = pc;
        task_en = en; page_chk = pg; precise_mode = pm; line_tag = mt; derr_clear = clr;
        #1;
        chk(line_addr == va[59:6], "R8", {10'd0, line_addr}, {10'd0, va[59:6]});
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; derr_clear = 1'b0;
        chk(rsp_valid == 1'b1, "R10", {63'd0, rsp_valid}, 64'd1);
        chk(rsp_verdict == ev, rq, {62'd0, rsp_verdict}, {62'd0, ev});
        chk(rsp_tt == ett, rq, {56'd0, rsp_tt}, {56'd0, ett});
        chk(rsp_addr == ea, rq, rsp_addr, ea);
        chk(derr_pending == m_pend, "R9", {63'd0, derr_pending}, {63'd0, m_pend});
        if (m_pend) chk(derr_pc == m_pc, "R9", derr_pc, m_pc);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R11", {63'd0, rsp_valid}, 64'd0);
        chk(derr_pending == 1'b0, "R11", {63'd0, derr_pending}, 64'd0);
        chk(req_ready == 1'b1, "R11", {63'd0, req_ready}, 64'd1);
        rst_n = 1'b1;

        // R1 match, R2 gating, R3 wildcards
        do_req(2'b01, 64'h5000_0000_1234_5678, 64'h100, 1, 1, 0, 4'h5, 0);
        do_req(2'b01, 64'h5000_0000_1234_5678, 64'h104, 0, 1, 0, 4'h6, 0);
        do_req(2'b00, 64'h5000_0000_1234_5678, 64'h108, 1, 0, 0, 4'h6, 0);
        do_req(2'b01, 64'h5000_0000_0000_0040, 64'h10c, 1, 1, 0, 4'h0, 0);
        do_req(2'b00, 64'h5000_0000_0000_0080, 64'h110, 1, 1, 0, 4'hf, 0);
        do_req(2'b01, 64'h0000_0000_0000_00c0, 64'h114, 1, 1, 0, 4'h7, 0);
        do_req(2'b01, 64'hf000_0000_0000_0100, 64'h118, 1, 1, 1, 4'h7, 0);
        // R4 and R9: first disrupting store, then a second keeps the first PC
        do_req(2'b01, 64'ha000_0000_0000_1000, 64'h2000, 1, 1, 0, 4'h3, 0);
        do_req(2'b01, 64'ha000_0000_0000_2000, 64'h3000, 1, 1, 0, 4'h4, 0);
        // R9: clear releases the flag
        @(negedge clk);
        derr_clear = 1'b1;
        @(negedge clk);
        derr_clear = 1'b0;
        m_pend = 1'b0;
        chk(derr_pending == 1'b0, "R9", {63'd0, derr_pending}, 64'd0);
        do_req(2'b01, 64'ha000_0000_0000_3000, 64'h4000, 1, 1, 0, 4'h4, 0);
        // R9: clear with a new disrupting store records the new PC
        do_req(2'b01, 64'ha000_0000_0000_4000, 64'h5000, 1, 1, 0, 4'h4, 1);
        // R5 precise store, R6 loads, R7 non-faulting load
        do_req(2'b01, 64'h9000_0000_dead_bee0, 64'h600, 1, 1, 1, 4'h2, 0);
        do_req(2'b00, 64'h9000_0000_dead_bee8, 64'h604, 1, 1, 0, 4'h2, 0);
        do_req(2'b11, 64'h9000_0000_dead_bef0, 64'h608, 1, 1, 0, 4'h2, 0);
        do_req(2'b10, 64'h9000_0000_dead_bef8, 64'h60c, 1, 1, 0, 4'h2, 0);

        // R10: back-pressure holds the response
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_kind = 2'b01; req_vaddr = 64'h8000_0000_0000_0700;
        req_pc = 64'h700; task_en = 1; page_chk = 1; precise_mode = 1; line_tag = 4'h1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R10", {63'd0, rsp_valid}, 64'd1);
        chk(req_ready == 1'b0, "R10", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
        chk(rsp_valid == 1'b1 && rsp_verdict == 2'b01, "R10", {62'd0, rsp_verdict}, 64'd1);
        chk(rsp_addr == 64'h8000_0000_0000_0700, "R10", rsp_addr, 64'h8000_0000_0000_0700);
        rsp_ready = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10", {63'd0, rsp_valid}, 64'd0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  k;
            logic [3:0]  pt;
            logic [3:0]  mt;
            logic [63:0] va;
            k  = 2'($urandom % 4);
            pt = 4'($urandom);
            mt = ($urandom % 3 == 0) ? pt : 4'($urandom);
            va = {pt, 28'($urandom), 32'($urandom)};
            do_req(k, va, {32'($urandom), 32'($urandom)}, ($urandom % 4) != 0,
                   ($urandom % 4) != 0, 1'($urandom), mt, ($urandom % 8) == 0);
        end
        finish_run();
    end
endmodule